// File: doc/BRIEF.md
# Single-Cycle Core with Quarter Store

This block is a 32-bit load/store processor core that completes one instruction per clock. Each cycle it fetches a word from a small internal instruction memory, decodes it, reads two registers, runs the ALU, and then either writes a register, writes the data memory, or changes the program counter. The instruction set has five register-to-register operations (add, subtract, and, or, signed set-less-than), plus add-immediate, word load, word store, branch-if-equal and a quarter store. The quarter store computes an address as base register plus sign-extended offset. It then writes one quarter of a second register's value to data memory at that address, and it writes no register.

The quarter is formed by a dedicated path that shifts the store data right arithmetically by two places before it reaches the memory write port. Address generation stays on the ordinary ALU add. A load port fills both memories while reset is held, and a combinational debug port reads any register or data word, so the core can be loaded, run and inspected from outside.

Top module: `quartet_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0; `pc_o` shows the program counter.
- R2: Every instruction that is not a taken branch advances the program counter by 4.
- R3: Opcode 0 is register type: rs = bits [25:21], rt = bits [20:16], rd = bits [15:11], function in bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0); the result is written to rd.
- R4: Opcode 0x08 writes rt with rs plus the sign-extended bits [15:0].
- R5: Opcode 0x23 loads rt from data memory and opcode 0x2B stores rt to data memory, both at rs plus the sign-extended offset; the word index is address bits [DMEM_AW+1:2], and higher address bits are ignored.
- R6: Opcode 0x04 compares rs with rt; when they are equal the next PC is PC+4 plus the sign-extended offset shifted left by 2, otherwise PC+4.
- R7: Opcode 0x2C stores rt arithmetically shifted right by 2 (integer divide by 4, rounded toward minus infinity) at rs plus the sign-extended offset, and writes no register.
- R8: Register 0 always reads 0, and writes to it are dropped.
- R9: Any other opcode writes neither a register nor data memory and only advances the PC.
- R10: With `ld_en` high, `ld_sel` = 0 writes `ld_data` to instruction word `ld_addr` and `ld_sel` = 1 writes data word `ld_addr`. `dbg_data` returns register `dbg_addr[4:0]` when `dbg_sel` = 0, and data word `dbg_addr` when `dbg_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory load strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | PORT_AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_sel | input | 1 | Debug source: 0 register file, 1 data memory |
| dbg_addr | input | PORT_AW | Register number or data word index to read |
| dbg_data | output | 32 | Debug read value |
| pc_o | output | 32 | Current program counter |

## Verification
The quarter store is driven with positive, odd, negative and most-negative operands. A design that shifted logically, divided with truncation toward zero, or stored the unshifted register would leave a wrong word in memory, for example 0xFFFFFFFF instead of 0xFFFFFFFE for -7. Quarter stores whose offset sets bits [15:11], and others whose address overflows the memory index, show whether a register is wrongly written or the address is wrongly decoded. Forward, backward and not-taken branches, unknown opcodes placed where they could write, and random mixed programs with register 0 as destination are each compared against a bench instruction model. That comparison exposes a wrong branch target, a stray write or a corrupted zero register.

// File: rtl/quartet_core.sv
`timescale 1ns/1ps
module quartet_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int MEM_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  localparam int PORT_AW = (MEM_AW > 5) ? MEM_AW : 5
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic               ld_sel,
  input  logic [PORT_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  input  logic               dbg_sel,
  input  logic [PORT_AW-1:0] dbg_addr,
  output logic [31:0]        dbg_data,
  output logic [31:0]        pc_o
);
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_STQ  = 6'h2C;

  logic [31:0] imem [IWORDS];
  logic [31:0] dmem [DWORDS];
  logic [31:0] rf   [32];

  logic [31:0] pc, instr, rd1, rd2, imm, alu_b, alu_y, wb, dm_rdata, dm_wdata;
  logic [31:0] pc_plus4, br_tgt;
  logic [4:0]  wa;
  logic        reg_dst, reg_wr, alu_src, mem_rd, mem_wr, mem_to_reg, branch, st_quarter;
  logic [1:0]  alu_op;
  logic        rf_we, dm_we, zero;

  wire [5:0] opc   = instr[31:26];
  wire [4:0] rs    = instr[25:21];
  wire [4:0] rt    = instr[20:16];
  wire [4:0] rd    = instr[15:11];
  wire [5:0] funct = instr[5:0];

  assign instr = imem[pc[IMEM_AW+1:2]];
  assign imm   = {{16{instr[15]}}, instr[15:0]};

  always_comb begin
    reg_dst = 1'b0; reg_wr = 1'b0; alu_src = 1'b0; mem_rd = 1'b0;
    mem_wr = 1'b0; mem_to_reg = 1'b0; branch = 1'b0; st_quarter = 1'b0;
    alu_op = 2'b00;
    case (opc)
      OP_REG:  begin reg_dst = 1'b1; reg_wr = 1'b1; alu_op = 2'b10; end
      OP_ADDI: begin reg_wr = 1'b1; alu_src = 1'b1; end
      OP_LW:   begin reg_wr = 1'b1; alu_src = 1'b1; mem_rd = 1'b1; mem_to_reg = 1'b1; end
      OP_SW:   begin alu_src = 1'b1; mem_wr = 1'b1; end
      OP_STQ:  begin alu_src = 1'b1; mem_wr = 1'b1; st_quarter = 1'b1; end
      OP_BEQ:  begin branch = 1'b1; alu_op = 2'b01; end
      default: ;
    endcase
  end

  assign rd1   = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rd2   = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b = alu_src ? imm : rd2;

  always_comb begin
    case (alu_op)
      2'b00:   alu_y = rd1 + alu_b;
      2'b01:   alu_y = rd1 - alu_b;
      default:
        case (funct)
          6'h22:   alu_y = rd1 - alu_b;
          6'h24:   alu_y = rd1 & alu_b;
          6'h25:   alu_y = rd1 | alu_b;
          6'h2A:   alu_y = {31'd0, $signed(rd1) < $signed(alu_b)};
          default: alu_y = rd1 + alu_b;
        endcase
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign dm_rdata = mem_rd ? dmem[alu_y[DMEM_AW+1:2]] : 32'd0;
  assign dm_wdata = st_quarter ? {{2{rd2[31]}}, rd2[31:2]} : rd2;
  assign wb       = mem_to_reg ? dm_rdata : alu_y;
  assign wa       = reg_dst ? rd : rt;
  assign rf_we    = reg_wr & ~rst & (wa != 5'd0);
  assign dm_we    = mem_wr & ~rst;

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm[29:0], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= (branch && zero) ? br_tgt : pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rf_we) begin
      rf[wa] <= wb;
    end
  end

  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DMEM_AW+1:2]] <= dm_wdata;
    if (ld_en && ld_sel) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  assign dbg_data = dbg_sel ? dmem[dbg_addr[DMEM_AW-1:0]]
                            : ((dbg_addr[4:0] == 5'd0) ? 32'd0 : rf[dbg_addr[4:0]]);
  assign pc_o = pc;
endmodule

// File: rtl/quartet_core_chk.sv
`timescale 1ns/1ps
module quartet_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [5:0]  opc,
  input logic [31:0] rd1,
  input logic [31:0] rd2,
  input logic [31:0] imm,
  input logic        rf_we,
  input logic        dm_we,
  input logic        dbg_sel,
  input logic [4:0]  dbg_ra,
  input logic [31:0] dbg_data
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'h04) |=> pc == $past(pc) + 32'd4);

  // R6
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h04 && rd1 == rd2) |=> pc == $past(pc) + 32'd4 + ($past(imm) << 2));

  // R6
  br_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h04 && rd1 != rd2) |=> pc == $past(pc) + 32'd4);

  // R7
  stq_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h2C) |-> (dm_we && !rf_we));

  // R9
  nop_op_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'h00 && opc != 6'h08 && opc != 6'h23 && opc != 6'h2B &&
     opc != 6'h04 && opc != 6'h2C) |-> (!dm_we && !rf_we));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (!dbg_sel && dbg_ra == 5'd0) |-> dbg_data == 32'd0);
endmodule

bind quartet_core quartet_core_chk i_quartet_core_chk (
  .clk(clk), .rst(rst), .pc(pc), .opc(instr[31:26]), .rd1(rd1), .rd2(rd2),
  .imm(imm), .rf_we(rf_we), .dm_we(dm_we), .dbg_sel(dbg_sel),
  .dbg_ra(dbg_addr[4:0]), .dbg_data(dbg_data)
);

// File: tb/test_quartet_core.sv
`timescale 1ns/1ps
module test_quartet_core;
  localparam int IAW = 6, DAW = 6, IW = 1 << IAW, DW = 1 << DAW;

  logic clk = 1'b0, rst = 1'b1, ld_en = 1'b0, ld_sel = 1'b0, dbg_sel = 1'b0;
  logic [5:0] ld_addr = '0, dbg_addr = '0;
  logic [31:0] ld_data = '0, dbg_data, pc_o;
  int checks = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_im [IW];
  logic [31:0] m_dm [DW];
  logic [31:0] m_rf [32];

  quartet_core i_quartet_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .pc_o(pc_o));

  always #2 clk = ~clk;

  function automatic logic [31:0] rtype(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [5:0] f);
    return {6'h00, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, logic [4:0] s, logic [4:0] t, logic [15:0] im);
    return {op, s, t, im};
  endfunction
  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd_dbg(logic sel, int a, output logic [31:0] v);
    @(negedge clk);
    dbg_sel = sel; dbg_addr = 6'(a);
    #1 v = dbg_data;
  endtask

  task automatic ref_run(output logic [31:0] end_pc, output int steps);
    logic [31:0] p, w, a, b, im, ad;
    p = 0; steps = 0;
    for (int s = 0; s < 4000; s++) begin
      w = m_im[p[IAW+1:2]];
      if (w == HALT) break;
      steps++;
      a  = m_rf[w[25:21]];
      b  = m_rf[w[20:16]];
      im = {{16{w[15]}}, w[15:0]};
      ad = a + im;
      p  = p + 4;
      case (w[31:26])
        6'h00: if (w[15:11] != 0)
          case (w[5:0])
            6'h22: m_rf[w[15:11]] = a - b;
            6'h24: m_rf[w[15:11]] = a & b;
            6'h25: m_rf[w[15:11]] = a | b;
            6'h2A: m_rf[w[15:11]] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: m_rf[w[15:11]] = a + b;
          endcase
        6'h08: if (w[20:16] != 0) m_rf[w[20:16]] = ad;
        6'h23: if (w[20:16] != 0) m_rf[w[20:16]] = m_dm[ad[DAW+1:2]];
        6'h2B: m_dm[ad[DAW+1:2]] = b;
        6'h2C: m_dm[ad[DAW+1:2]] = $signed(b) >>> 2;
        6'h04: if (a == b) p = p + (im << 2);
        default: ;
      endcase
    end
    end_pc = p;
  endtask

  task automatic fill(int n_used);
    for (int i = n_used; i < IW; i++) m_im[i] = HALT;
    for (int i = 0; i < DW; i++) m_dm[i] = $urandom;
  endtask

  task automatic run_prog(string tag, bit seq_pc);
    logic [31:0] v, end_pc;
    int steps;
    rst = 1'b1;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_sel = 1'b0; ld_addr = 6'(i); ld_data = m_im[i];
    end
    for (int i = 0; i < DW; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 6'(i); ld_data = m_dm[i];
    end
    @(negedge clk); ld_en = 1'b0;
    for (int r = 1; r < 32; r++) begin
      rd_dbg(1'b0, r, v); chk("R1", $sformatf("reg %0d cleared", r), v, 32'd0);
    end
    rd_dbg(1'b1, 5, v);  chk("R10", "dmem load word 5", v, m_dm[5]);
    rd_dbg(1'b1, 63, v); chk("R10", "dmem load word 63", v, m_dm[63]);
    for (int r = 0; r < 32; r++) m_rf[r] = 32'd0;
    ref_run(end_pc, steps);
    @(negedge clk);
    chk("R1", "pc held in reset", pc_o, 32'd0);
    rst = 1'b0;
    if (seq_pc) begin
      @(negedge clk); chk("R2", "pc after 1st", pc_o, 32'd4);
      @(negedge clk); chk("R2", "pc after 2nd", pc_o, 32'd8);
    end
    repeat (steps + 4) @(negedge clk);
    chk("R2 R6", {tag, " final pc"}, pc_o, end_pc);
    rd_dbg(1'b0, 0, v); chk("R8", {tag, " reg 0"}, v, 32'd0);
    for (int r = 1; r < 32; r++) begin
      rd_dbg(1'b0, r, v);
      chk("R3 R4 R5 R9", $sformatf("%s reg %0d", tag, r), v, m_rf[r]);
    end
    for (int i = 0; i < DW; i++) begin
      rd_dbg(1'b1, i, v);
      chk("R5 R7 R9", $sformatf("%s dmem %0d", tag, i), v, m_dm[i]);
    end
  endtask

  task automatic gen_random(int n);
    logic [5:0] fn [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    logic [5:0] bad_op [4] = '{6'h3F, 6'h2D, 6'h10, 6'h01};
    for (int i = 0; i < n; i++) begin
      int k;
      logic [4:0] a, b, c;
      k = $urandom_range(0, 9);
      a = 5'($urandom_range(0, 7)); b = 5'($urandom_range(0, 7)); c = 5'($urandom_range(0, 7));
      case (k)
        0, 1:    m_im[i] = itype(6'h08, a, b, 16'($urandom));
        2, 3, 4: m_im[i] = rtype(a, b, c, fn[$urandom_range(0, 4)]);
        5:       m_im[i] = itype(6'h2B, 5'd0, b, 16'($urandom_range(0, 63) * 4));
        6:       m_im[i] = itype(6'h23, 5'd0, b, 16'($urandom_range(0, 63) * 4));
        7, 8:    m_im[i] = itype(6'h2C, 5'd0, b, 16'($urandom_range(0, 63) * 4));
        default: m_im[i] = itype(bad_op[$urandom_range(0, 3)], a, b, 16'($urandom));
      endcase
    end
    m_im[0] = itype(6'h08, 5'd1, 5'd1, 16'($urandom));
    m_im[1] = itype(6'h08, 5'd2, 5'd2, 16'($urandom));
  endtask

  initial begin
    logic [31:0] v, d0;
    void'($urandom(32'd2024));

    // R7 directed quarter stores
    fill(11);
    m_dm[20] = 32'h8000_0003;
    m_im[0]  = itype(6'h08, 5'd0, 5'd1, 16'd32);
    m_im[1]  = itype(6'h08, 5'd0, 5'd2, 16'd16);
    m_im[2]  = itype(6'h2C, 5'd1, 5'd2, 16'd8);
    m_im[3]  = itype(6'h08, 5'd0, 5'd3, 16'hFFF9);
    m_im[4]  = itype(6'h2C, 5'd0, 5'd3, 16'd0);
    m_im[5]  = itype(6'h23, 5'd0, 5'd4, 16'd80);
    m_im[6]  = itype(6'h2C, 5'd1, 5'd4, 16'hFFFC);
    m_im[7]  = itype(6'h08, 5'd0, 5'd5, 16'd7);
    m_im[8]  = itype(6'h2C, 5'd0, 5'd5, 16'd12);
    m_im[9]  = itype(6'h2C, 5'd0, 5'd3, 16'h0804);
    m_im[10] = itype(6'h2C, 5'd0, 5'd0, 16'd24);
    run_prog("stq", 1'b1);
    rd_dbg(1'b1, 10, v); chk("R7", "16/4", v, 32'd4);
    rd_dbg(1'b1, 0, v);  chk("R7", "-7/4 floor", v, 32'hFFFF_FFFE);
    rd_dbg(1'b1, 7, v);  chk("R7", "most-negative quarter", v, 32'hE000_0000);
    rd_dbg(1'b1, 3, v);  chk("R7", "7/4", v, 32'd1);
    rd_dbg(1'b1, 1, v);  chk("R5 R7", "wrapped address", v, 32'hFFFF_FFFE);
    rd_dbg(1'b1, 6, v);  chk("R7 R8", "quarter of reg 0", v, 32'd0);
    rd_dbg(1'b0, 1, v);  chk("R7", "no reg write via rd field", v, 32'd32);
    rd_dbg(1'b0, 3, v);  chk("R7", "data reg unchanged", v, 32'hFFFF_FFF9);

    // R6 directed branches
    fill(13);
    m_im[0]  = itype(6'h08, 5'd0, 5'd1, 16'd5);
    m_im[1]  = itype(6'h08, 5'd0, 5'd2, 16'd5);
    m_im[2]  = itype(6'h04, 5'd1, 5'd2, 16'd2);
    m_im[3]  = itype(6'h08, 5'd0, 5'd3, 16'd1);
    m_im[4]  = itype(6'h08, 5'd0, 5'd3, 16'd2);
    m_im[5]  = itype(6'h08, 5'd0, 5'd4, 16'd9);
    m_im[6]  = itype(6'h04, 5'd1, 5'd0, 16'd1);
    m_im[7]  = itype(6'h08, 5'd0, 5'd5, 16'd3);
    m_im[8]  = itype(6'h08, 5'd0, 5'd6, 16'd3);
    m_im[9]  = itype(6'h08, 5'd6, 5'd6, 16'hFFFF);
    m_im[10] = itype(6'h04, 5'd6, 5'd0, 16'd1);
    m_im[11] = itype(6'h04, 5'd0, 5'd0, 16'hFFFD);
    m_im[12] = itype(6'h08, 5'd7, 5'd7, 16'd1);
    run_prog("branch", 1'b1);
    chk("R6", "halt pc", pc_o, 32'd52);
    rd_dbg(1'b0, 3, v); chk("R6", "taken skip", v, 32'd0);
    rd_dbg(1'b0, 5, v); chk("R6", "not taken falls through", v, 32'd3);
    rd_dbg(1'b0, 6, v); chk("R6", "backward loop count", v, 32'd0);

    // R9 directed unknown opcodes
    fill(5);
    d0 = m_dm[0];
    m_im[0] = itype(6'h08, 5'd0, 5'd1, 16'd7);
    m_im[1] = itype(6'h3F, 5'd1, 5'd2, 16'h1800);
    m_im[2] = itype(6'h2D, 5'd0, 5'd1, 16'd0);
    m_im[3] = itype(6'h10, 5'd1, 5'd3, 16'h1804);
    m_im[4] = itype(6'h08, 5'd0, 5'd9, 16'd1);
    run_prog("unknown", 1'b1);
    chk("R9", "pc after no-ops", pc_o, 32'd20);
    rd_dbg(1'b0, 2, v); chk("R9", "rt untouched", v, 32'd0);
    rd_dbg(1'b0, 3, v); chk("R9", "rd untouched", v, 32'd0);
    rd_dbg(1'b1, 0, v); chk("R9", "dmem untouched", v, d0);

    // R3 R4 R5 R8 random programs
    for (int p = 0; p < 20; p++) begin
      fill(50);
      gen_random(50);
      run_prog($sformatf("rand%0d", p), 1'b1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule